// File: doc/BRIEF.md
# Eight-Bit ALU with Packed-BCD Correction

This block is the combinational arithmetic and logic unit of a small 8-bit accumulator processor. It takes an operation code, the accumulator (or whichever register the sequencer routes in), a memory operand, the current carry and the decimal-mode flag. It returns an 8-bit result, new values for the sign (N), zero (Z), carry (C) and overflow (V) flags, and one write-enable per flag. The write-enable tells the status register which flags the operation updates. A flag whose enable is low is driven as 0 and must be left alone by the register file.

Add and subtract work on a double-width intermediate. In decimal mode, a branch-free term computed from the binary sum and both operands adjusts each nibble of the sum. N, Z and V are taken from the binary sum before that adjustment. Carry and the result are taken after it. Compare and bit test report flags only: their result output simply echoes the register input.

The datapath width is a parameter with a default of 8. The decimal constants are built per nibble from that width.

Top module: `bcd_alu`

## Requirements
- R1: Operation code 0 (add), with decimal off, forms A + M + carry-in. The result is the low 8 bits. C is set when any bit above bit 7 of the sum is set. V is set when sum bit 7 differs from both A bit 7 and the operand bit 7. N is result bit 7. Z is set when the low 8 bits are zero.
- R2: In decimal mode, add and subtract increase the binary sum s by 3 × ((((s + 0x66) ^ A ^ operand) >> 3) & 0x22) before the result and C are taken. N, Z and V still come from the unadjusted sum s.
- R3: Operation code 1 (subtract) replaces M by M ^ 0xFF and then runs the add path with the incoming carry. In decimal mode it also subtracts 0x66 from that complemented operand in 16-bit arithmetic before the add. A borrow wraps into the high byte and so affects C.
- R4: Operation code 2 (compare) sets Z and N from (A − M) mod 256 and sets C when A ≥ M unsigned. It ignores carry-in and decimal mode, does not write V, and returns A as the result.
- R5: Operation codes 3, 4 and 5 (AND, OR, XOR) return the bitwise result of A and M. They write only N and Z, taken from that result.
- R6: Operation code 6 (bit test) sets Z when A & M is zero and copies M bit 7 into N and M bit 6 into V. It does not write C and returns A.
- R7: Operation code 7 (shift left) returns A << 1 and moves A bit 7 into C. Operation code 8 (logical shift right) returns A >> 1 with bit 7 clear and moves A bit 0 into C. Both write N, Z and C but not V.
- R8: Operation code 9 (rotate left) puts carry-in into bit 0 and moves A bit 7 into C. Operation code 10 (rotate right) puts carry-in into bit 7 and moves A bit 0 into C. Both write N, Z and C but not V.
- R9: Each flag output is 0 whenever its write-enable is low. Codes 11 to 15 return A and raise no write-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 4 | Operation code |
| accIn | input | 8 | Register operand (A) |
| memIn | input | 8 | Memory operand (M) |
| carryIn | input | 1 | Current carry flag |
| decimalIn | input | 1 | Decimal mode flag |
| result | output | 8 | Operation result |
| flagN | output | 1 | New sign flag |
| flagZ | output | 1 | New zero flag |
| flagC | output | 1 | New carry flag |
| flagV | output | 1 | New overflow flag |
| wrN | output | 1 | Sign flag is updated |
| wrZ | output | 1 | Zero flag is updated |
| wrC | output | 1 | Carry flag is updated |
| wrV | output | 1 | Overflow flag is updated |

## Verification
The assertions hold on every evaluation for the cheap local relations:
- unwritten flags read 0;
- logic operations never raise the C or V enables;
- bit test copies M bits 7 and 6;
- compare carry matches an unsigned A ≥ M;
- shift and rotate carries and fill bits come from the right places.

The decimal correction depends on the whole binary sum, so only the bench scenarios can show it. It also depends on the wrap of the 0x66 pre-subtraction and on N, Z and V being taken before adjustment. The bench therefore sweeps every pair of valid BCD bytes through add and subtract in decimal mode, and adds mixed random traffic over all codes.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_CMP = 4'd2,
    OP_AND = 4'd3,
    OP_OR  = 4'd4,
    OP_XOR = 4'd5,
    OP_BIT = 4'd6,
    OP_ASL = 4'd7,
    OP_LSR = 4'd8,
    OP_ROL = 4'd9,
    OP_ROR = 4'd10
  } aluOp_e;

  typedef enum logic [2:0] {
    U_PASS  = 3'd0,
    U_ARITH = 3'd1,
    U_LOGIC = 3'd2,
    U_BIT   = 3'd3,
    U_SHIFT = 3'd4
  } unitSel_e;

  typedef enum logic [1:0] {
    L_AND = 2'd0,
    L_OR  = 2'd1,
    L_XOR = 2'd2
  } logicSel_e;

  // strobes from control to datapath
  typedef struct packed {
    unitSel_e  unit;
    logicSel_e logicFn;
    logic      invOperand;  // complement memory operand
    logic      decSub;      // remove 0x66.. from complemented operand
    logic      decAdj;      // apply nibble correction to the sum
    logic      forceCarry;  // carry-in forced to one
    logic      shiftLeft;
    logic      shiftRot;    // rotate uses carry-in as fill bit
    logic      wrN;
    logic      wrZ;
    logic      wrC;
    logic      wrV;
  } ctrlStrobes_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0]   opSel,
  input  logic         decimalIn,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes            = '0;
    strobes.unit       = U_PASS;
    strobes.logicFn    = L_AND;
    unique case (opSel)
      OP_ADD: begin
        strobes.unit   = U_ARITH;
        strobes.decAdj = decimalIn;
        {strobes.wrN, strobes.wrZ, strobes.wrC, strobes.wrV} = 4'b1111;
      end
      OP_SUB: begin
        strobes.unit       = U_ARITH;
        strobes.invOperand = 1'b1;
        strobes.decSub     = decimalIn;
        strobes.decAdj     = decimalIn;
        {strobes.wrN, strobes.wrZ, strobes.wrC, strobes.wrV} = 4'b1111;
      end
      OP_CMP: begin
        strobes.unit       = U_ARITH;
        strobes.invOperand = 1'b1;
        strobes.forceCarry = 1'b1;
        {strobes.wrN, strobes.wrZ, strobes.wrC} = 3'b111;
      end
      OP_AND, OP_OR, OP_XOR: begin
        strobes.unit    = U_LOGIC;
        strobes.logicFn = (opSel == OP_AND) ? L_AND :
                          (opSel == OP_OR)  ? L_OR  : L_XOR;
        {strobes.wrN, strobes.wrZ} = 2'b11;
      end
      OP_BIT: begin
        strobes.unit = U_BIT;
        {strobes.wrN, strobes.wrZ, strobes.wrV} = 3'b111;
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        strobes.unit      = U_SHIFT;
        strobes.shiftLeft = (opSel == OP_ASL) || (opSel == OP_ROL);
        strobes.shiftRot  = (opSel == OP_ROL) || (opSel == OP_ROR);
        {strobes.wrN, strobes.wrZ, strobes.wrC} = 3'b111;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_dpath.sv
module alu_dpath
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  ctrlStrobes_t strobes,
  input  logic [W-1:0] accIn,
  input  logic [W-1:0] memIn,
  input  logic         carryIn,
  output logic [W-1:0] result,
  output logic         flagN,
  output logic         flagZ,
  output logic         flagC,
  output logic         flagV
);

  localparam int XW     = 2 * W;
  localparam int DIGITS = W / 4;

  function automatic logic [XW-1:0] sixesConst();
    logic [XW-1:0] r;
    r = '0;
    for (int i = 0; i < DIGITS; i++) r[4*i +: 4] = 4'h6;
    return r;
  endfunction

  // after the >>3, bit 4k+1 marks a carry out of nibble k
  function automatic logic [XW-1:0] nibbleMask();
    logic [XW-1:0] r;
    r = '0;
    for (int i = 0; i < DIGITS; i++) r[4*i + 1] = 1'b1;
    return r;
  endfunction

  localparam logic [XW-1:0] SIXES = sixesConst();
  localparam logic [XW-1:0] MASK  = nibbleMask();

  // ---------------- arithmetic path ----------------
  logic [XW-1:0] accExt, opnd, sumBin, probe, marks, adjust, sumFin;
  logic          cEff;
  logic          arN, arZ, arC, arV;

  always_comb begin
    accExt = {{W{1'b0}}, accIn};
    opnd   = strobes.invOperand ? {{W{1'b0}}, ~memIn} : {{W{1'b0}}, memIn};
    if (strobes.decSub) opnd = opnd - SIXES;
    cEff   = strobes.forceCarry | carryIn;
    sumBin = accExt + opnd + {{(XW-1){1'b0}}, cEff};
    probe  = (sumBin + SIXES) ^ accExt ^ opnd;
    marks  = (probe >> 3) & MASK;
    adjust = marks + (marks << 1);
    sumFin = strobes.decAdj ? (sumBin + adjust) : sumBin;
    arN    = sumBin[W-1];
    arZ    = (sumBin[W-1:0] == '0);
    arV    = (sumBin[W-1] ^ accIn[W-1]) & (sumBin[W-1] ^ opnd[W-1]);
    arC    = |sumFin[XW-1:W];
  end

  // ---------------- logic path ----------------
  logic [W-1:0] logicRes;
  always_comb begin
    unique case (strobes.logicFn)
      L_OR:    logicRes = accIn | memIn;
      L_XOR:   logicRes = accIn ^ memIn;
      default: logicRes = accIn & memIn;
    endcase
  end

  // ---------------- shift path ----------------
  logic [W-1:0] shiftRes;
  logic         shiftC, fillBit;
  always_comb begin
    fillBit = strobes.shiftRot & carryIn;
    if (strobes.shiftLeft) begin
      shiftRes = {accIn[W-2:0], fillBit};
      shiftC   = accIn[W-1];
    end else begin
      shiftRes = {fillBit, accIn[W-1:1]};
      shiftC   = accIn[0];
    end
  end

  // ---------------- output select ----------------
  logic [W-1:0] resSel;
  logic         nSel, zSel, cSel, vSel;
  always_comb begin
    resSel = accIn;
    nSel = 1'b0; zSel = 1'b0; cSel = 1'b0; vSel = 1'b0;
    unique case (strobes.unit)
      U_ARITH: begin
        resSel = (strobes.forceCarry && strobes.invOperand) ? accIn : sumFin[W-1:0];
        nSel = arN; zSel = arZ; cSel = arC; vSel = arV;
      end
      U_LOGIC: begin
        resSel = logicRes;
        nSel = logicRes[W-1]; zSel = (logicRes == '0);
      end
      U_BIT: begin
        nSel = memIn[W-1]; vSel = memIn[W-2];
        zSel = ((accIn & memIn) == '0);
      end
      U_SHIFT: begin
        resSel = shiftRes;
        nSel = shiftRes[W-1]; zSel = (shiftRes == '0); cSel = shiftC;
      end
      default: ;
    endcase
  end

  assign result = resSel;
  assign flagN  = nSel & strobes.wrN;
  assign flagZ  = zSel & strobes.wrZ;
  assign flagC  = cSel & strobes.wrC;
  assign flagV  = vSel & strobes.wrV;

endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   opSel,
  input  logic [W-1:0] accIn,
  input  logic [W-1:0] memIn,
  input  logic         carryIn,
  input  logic         decimalIn,
  output logic [W-1:0] result,
  output logic         flagN,
  output logic         flagZ,
  output logic         flagC,
  output logic         flagV,
  output logic         wrN,
  output logic         wrZ,
  output logic         wrC,
  output logic         wrV
);

  ctrlStrobes_t strobes;

  alu_ctrl u_ctrl (
    .opSel     (opSel),
    .decimalIn (decimalIn),
    .strobes   (strobes)
  );

  alu_dpath #(.W(W)) u_dpath (
    .strobes (strobes),
    .accIn   (accIn),
    .memIn   (memIn),
    .carryIn (carryIn),
    .result  (result),
    .flagN   (flagN),
    .flagZ   (flagZ),
    .flagC   (flagC),
    .flagV   (flagV)
  );

  assign wrN = strobes.wrN;
  assign wrZ = strobes.wrZ;
  assign wrC = strobes.wrC;
  assign wrV = strobes.wrV;

endmodule

// File: rtl/alu_chk.sv
module alu_chk #(
  parameter int W = 8
) (
  input logic [3:0]   opSel,
  input logic [W-1:0] accIn,
  input logic [W-1:0] memIn,
  input logic         carryIn,
  input logic         decimalIn,
  input logic [W-1:0] result,
  input logic         flagN,
  input logic         flagZ,
  input logic         flagC,
  input logic         flagV,
  input logic         wrN,
  input logic         wrZ,
  input logic         wrC,
  input logic         wrV
);

  logic known;
  assign known = !$isunknown({opSel, accIn, memIn, carryIn, decimalIn});

  always_comb begin
    if (known) begin
      // R9: a flag whose enable is low reads zero
      p_quiet_flags_r9: assert ((wrN || !flagN) && (wrZ || !flagZ) &&
                                (wrC || !flagC) && (wrV || !flagV))
        else $error("unwritten flag driven high");
      // R5: logic operations leave carry and overflow alone
      p_logic_keeps_cv_r5: assert (!(opSel >= 4'd3 && opSel <= 4'd5) || (!wrC && !wrV))
        else $error("logic op wrote C or V");
      // R6: bit test copies operand bits into N and V
      p_bit_copies_r6: assert (opSel != 4'd6 ||
                               (flagN == memIn[W-1] && flagV == memIn[W-2] && !wrC))
        else $error("bit test flags wrong");
      // R4: compare carry is an unsigned greater-or-equal
      p_cmp_carry_r4: assert (opSel != 4'd2 || (flagC == (accIn >= memIn) && result == accIn))
        else $error("compare carry wrong");
      // R7: shift carries come from the edge bit, logical right clears the top
      p_shift_edge_r7: assert ((opSel != 4'd7 || flagC == accIn[W-1]) &&
                               (opSel != 4'd8 || (flagC == accIn[0] && !result[W-1])))
        else $error("shift edge wrong");
      // R8: rotates fill from carry-in
      p_rot_fill_r8: assert ((opSel != 4'd9 || result[0] == carryIn) &&
                             (opSel != 4'd10 || result[W-1] == carryIn))
        else $error("rotate fill wrong");
    end
  end

endmodule

bind bcd_alu alu_chk #(.W(W)) u_chk (
  .opSel(opSel), .accIn(accIn), .memIn(memIn), .carryIn(carryIn),
  .decimalIn(decimalIn), .result(result), .flagN(flagN), .flagZ(flagZ),
  .flagC(flagC), .flagV(flagV), .wrN(wrN), .wrZ(wrZ), .wrC(wrC), .wrV(wrV)
);

// File: tb/sim_bcd_alu.sv
module sim_bcd_alu;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] opSel = '0;
  logic [7:0] accIn = '0;
  logic [7:0] memIn = '0;
  logic       carryIn = 1'b0;
  logic       decimalIn = 1'b0;
  logic [7:0] result;
  logic       flagN, flagZ, flagC, flagV, wrN, wrZ, wrC, wrV;

  bcd_alu u0 (
    .opSel(opSel), .accIn(accIn), .memIn(memIn), .carryIn(carryIn),
    .decimalIn(decimalIn), .result(result), .flagN(flagN), .flagZ(flagZ),
    .flagC(flagC), .flagV(flagV), .wrN(wrN), .wrZ(wrZ), .wrC(wrC), .wrV(wrV)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [3:0] op;
    logic       dec;
    logic [7:0] res;
    logic [3:0] flg;  // N Z C V
    logic [3:0] wr;   // N Z C V
  } exp_t;

  exp_t q[$];
  int   nCmp = 0;
  int   nBad = 0;
  bit   driveDone = 1'b0;

  function automatic string tagOf(logic [3:0] op, logic dec);
    case (op)
      4'd0:               return dec ? "R2" : "R1";
      4'd1:               return dec ? "R3/R2" : "R3";
      4'd2:               return "R4";
      4'd3, 4'd4, 4'd5:   return "R5";
      4'd6:               return "R6";
      4'd7, 4'd8:         return "R7";
      4'd9, 4'd10:        return "R8";
      default:            return "R9";
    endcase
  endfunction

  // reference model written from the requirements
  function automatic exp_t model(logic [3:0] op, logic [7:0] a, logic [7:0] m,
                                 logic c, logic dec);
    exp_t e;
    logic [15:0] v, s;
    logic [7:0]  d;
    logic n, z, cf, vf;
    e = '0; e.op = op; e.dec = dec;
    n = 0; z = 0; cf = 0; vf = 0;
    e.res = a;
    case (op)
      4'd0, 4'd1: begin  // R1 R2 R3
        v = {8'h00, m};
        if (op == 4'd1) begin
          v = v ^ 16'h00FF;
          if (dec) v = v - 16'h0066;
        end
        s  = {8'h00, a} + v + {15'd0, c};
        n  = s[7];
        z  = (s[7:0] == 8'h00);
        vf = (((s ^ {8'h00, a}) & (s ^ v) & 16'h0080) != 16'h0000);
        if (dec) s = s + ((((s + 16'h0066) ^ {8'h00, a} ^ v) >> 3) & 16'h0022) * 16'd3;
        cf = ((s & 16'hFF00) != 16'h0000);
        e.res = s[7:0];
        e.wr = 4'b1111;
      end
      4'd2: begin  // R4
        d = a - m; n = d[7]; z = (d == 8'h00); cf = (a >= m);
        e.wr = 4'b1110;
      end
      4'd3, 4'd4, 4'd5: begin  // R5
        e.res = (op == 4'd3) ? (a & m) : (op == 4'd4) ? (a | m) : (a ^ m);
        n = e.res[7]; z = (e.res == 8'h00);
        e.wr = 4'b1100;
      end
      4'd6: begin  // R6
        z = ((a & m) == 8'h00); n = m[7]; vf = m[6];
        e.wr = 4'b1101;
      end
      4'd7, 4'd8, 4'd9, 4'd10: begin  // R7 R8
        case (op)
          4'd7:    begin e.res = {a[6:0], 1'b0}; cf = a[7]; end
          4'd8:    begin e.res = {1'b0, a[7:1]}; cf = a[0]; end
          4'd9:    begin e.res = {a[6:0], c};    cf = a[7]; end
          default: begin e.res = {c, a[7:1]};    cf = a[0]; end
        endcase
        n = e.res[7]; z = (e.res == 8'h00);
        e.wr = 4'b1110;
      end
      default: e.wr = 4'b0000;  // R9
    endcase
    e.flg = {n, z, cf, vf} & e.wr;  // R9: unwritten flags read zero
    return e;
  endfunction

  task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] m,
                       input logic c, input logic dec);
    @(posedge clk);
    #1;
    opSel = op; accIn = a; memIn = m; carryIn = c; decimalIn = dec;
    q.push_back(model(op, a, m, c, dec));
  endtask

  // monitor: compares at the falling edge, away from the driver's change
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        nCmp++;
        if (result !== e.res || {flagN, flagZ, flagC, flagV} !== e.flg ||
            {wrN, wrZ, wrC, wrV} !== e.wr) begin
          nBad++;
          $display("FAIL %s op=%0d dec=%0b: got res=%02h flg=%04b wr=%04b, expected res=%02h flg=%04b wr=%04b",
                   tagOf(e.op, e.dec), e.op, e.dec, result, {flagN, flagZ, flagC, flagV},
                   {wrN, wrZ, wrC, wrV}, e.res, e.flg, e.wr);
        end
      end
    end
  end

  // stimulus
  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    drive(4'd0, 8'h00, 8'h00, 1'b0, 1'b0);   // reset-state inputs, R1 Z set
    // R1 binary add: carry out and signed overflow
    drive(4'd0, 8'hFF, 8'h01, 1'b0, 1'b0);
    drive(4'd0, 8'h7F, 8'h01, 1'b0, 1'b0);
    drive(4'd0, 8'h80, 8'h80, 1'b1, 1'b0);
    // R2 decimal add: 09+01 -> 10, 99+01 -> 00 carry, 58+46+1 -> 05 carry
    drive(4'd0, 8'h09, 8'h01, 1'b0, 1'b1);
    drive(4'd0, 8'h99, 8'h01, 1'b0, 1'b1);
    drive(4'd0, 8'h58, 8'h46, 1'b1, 1'b1);
    // R3 subtract: binary, and decimal 00-01 -> 99 borrow, 50-20 -> 30, M=FF wrap
    drive(4'd1, 8'h10, 8'h01, 1'b1, 1'b0);
    drive(4'd1, 8'h00, 8'h01, 1'b1, 1'b1);
    drive(4'd1, 8'h50, 8'h20, 1'b1, 1'b1);
    drive(4'd1, 8'h00, 8'hFF, 1'b1, 1'b1);
    // R4 compare: equal, less, greater; carry-in and decimal ignored
    drive(4'd2, 8'h40, 8'h40, 1'b0, 1'b1);
    drive(4'd2, 8'h01, 8'h02, 1'b1, 1'b0);
    drive(4'd2, 8'hF0, 8'h10, 1'b0, 1'b0);
    // R5 logic ops with carry-in set: C and V stay unwritten
    drive(4'd3, 8'hF0, 8'h0F, 1'b1, 1'b0);
    drive(4'd4, 8'h80, 8'h01, 1'b1, 1'b0);
    drive(4'd5, 8'hAA, 8'hAA, 1'b1, 1'b1);
    // R6 bit test
    drive(4'd6, 8'h01, 8'hC0, 1'b1, 1'b0);
    drive(4'd6, 8'h41, 8'h41, 1'b0, 1'b0);
    // R7 shifts, R8 rotates
    drive(4'd7, 8'h81, 8'h00, 1'b1, 1'b0);
    drive(4'd8, 8'h01, 8'h00, 1'b1, 1'b0);
    drive(4'd9, 8'h80, 8'h00, 1'b1, 1'b0);
    drive(4'd10, 8'h01, 8'h00, 1'b1, 1'b0);
    // R9 undefined codes
    for (int k = 11; k < 16; k++) drive(4'(k), 8'h5A, 8'hFF, 1'b1, 1'b1);
    // R2 R3 sweep over all valid BCD byte pairs
    for (int i = 0; i < 100; i++) begin
      for (int j = 0; j < 100; j++) begin
        logic [7:0] ba, bm;
        ba = 8'(((i / 10) << 4) | (i % 10));
        bm = 8'(((j / 10) << 4) | (j % 10));
        drive(4'd0, ba, bm, 1'((i + j) % 2), 1'b1);
        drive(4'd1, ba, bm, 1'((i * j) % 2), 1'b1);
      end
    end
    // mixed traffic across all codes
    for (int r = 0; r < 3000; r++)
      drive(4'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
    @(posedge clk);
    driveDone = 1'b1;
  end

  // completion and watchdog
  initial begin
    int cyc;
    cyc = 0;
    while (!(driveDone && q.size() == 0) && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (cyc >= WATCHDOG) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog: got %0d cycles, expected fewer than %0d", cyc, WATCHDOG);
    end
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule